// File: doc/BRIEF.md
# Pseudo-Random Pattern Bit Error Checker

This block checks a serial test stream that is meant to carry a maximal-length pseudo-random sequence. One bit arrives per clock whenever `in_valid` is high. After a `start` pulse, the block loads the incoming bits straight into a local shift register, so it seeds itself from the stream. It watches how well the register predicts each next bit. Once the predictions have been right for a long unbroken run, it declares lock. From then on the register runs by itself. Every received bit is compared with the register's prediction.

Two wide counters record the compared bits and the mismatches. Their ratio is the measured bit error ratio. The test length comes from `target_bits`, which is normally set to -ln(1-C)/BER_goal. For a goal of 1e-12 at 95 % confidence this is roughly 3e12 bits, so the bit counter is 48 bits wide by default. When the bit count reaches that value, counting stops and `done` rises.

If errors become so dense that the local copy has clearly slipped, the block goes back to self-seeding. It also raises a sticky flag so that the interrupted measurement can be recognised.

Top module: `prbs_err_det`

## Requirements
- R1: A synchronous reset leaves `locked`, `done`, `loss_of_lock` and both counters at zero. A `start` pulse also clears the counters and the loss flag, clears the local register and begins a new synchronisation.
- R2: `order_sel` picks the generator x^o+x^t+1. The codes are: 0 gives (7,6), 1 gives (9,5), 2 gives (15,14), 3 gives (23,18) and 4 gives (31,28). Codes 5 to 7 act as code 0. The value is taken only in the `start` cycle, and later changes have no effect on the running test.
- R3: During synchronisation each valid bit is shifted into the local register. `locked` goes high in the cycle after the 64th consecutive valid bit that the register predicted correctly. With an error-free stream this happens after no fewer than 64 and no more than order+64 valid bits.
- R4: A prediction made from a register whose low `order` bits are all zero never counts toward lock, so an all-zero stream never locks.
- R5: While locked, each valid bit adds one to `bit_count`, and each valid bit that differs from the prediction adds one to `err_count`. Both counters are visible in the next cycle. Cycles with `in_valid` low change nothing, and bits received while not locked are not counted.
- R6: After lock the local register advances from its own prediction, not from the received bit. A single flipped bit therefore adds exactly one error.
- R7: When `bit_count` equals `target_bits`, no further bits are counted and `done` goes high in the next cycle. `done` then stays high until the next `start`.
- R8: The locked stream is split into windows of 256 counted bits. If a 17th error arrives within one window, the block drops `locked`, sets the sticky `loss_of_lock` and returns to synchronisation. It keeps its counts and can lock again.
- R9: Both counters saturate at all ones instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new test: clear the counters and flags and start synchronising |
| order_sel | input | SEL_W (3) | Sequence order code, taken on `start` |
| target_bits | input | CNT_W (48) | Compared-bit count that ends the test |
| in_valid | input | 1 | Qualifies `in_bit` |
| in_bit | input | 1 | Received serial bit |
| locked | output | 1 | Local generator is synchronised and bits are being compared |
| done | output | 1 | Target bit count reached |
| loss_of_lock | output | 1 | Sticky: lock was lost since the last `start` |
| bit_count | output | CNT_W (48) | Number of compared bits |
| err_count | output | ERR_W (32) | Number of mismatching compared bits |

## Verification
The bench injects errors deliberately: isolated flips, a burst of exactly 17, and a steady one-in-twenty rate. A design that fed received bits into the local register after lock would report two or more errors for each flip. A design with an off-by-one density limit would either survive the burst or drop on the 16th error. A design that wraps its counters would show a small error count after 295 flips into an 8-bit counter.

The bench also drives an all-zero stream, which must never lock. It gaps the strobe while driving junk data, which must leave the counts untouched. It changes the order code in the middle of a test, which must be ignored, and it uses an out-of-range order code. Finally it checks lock latency against the 64-match rule for every order, and checks that counting stops exactly at the target rather than one bit past it.

// File: rtl/prbs_det_pkg.sv
package prbs_det_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SYNC,
    ST_LOCK,
    ST_DONE
  } det_state_t;

  localparam int NUM_ORDERS = 5;
  localparam int MAX_ORDER  = 31;

  // highest tap (the order) for each selectable sequence
  function automatic int tap_hi(input int idx);
    case (idx)
      1:       return 9;
      2:       return 15;
      3:       return 23;
      4:       return 31;
      default: return 7;
    endcase
  endfunction

  // inner tap for each selectable sequence
  function automatic int tap_lo(input int idx);
    case (idx)
      1:       return 5;
      2:       return 14;
      3:       return 18;
      4:       return 28;
      default: return 6;
    endcase
  endfunction

endpackage

// File: rtl/prbs_predictor.sv
module prbs_predictor
  import prbs_det_pkg::*;
#(
  parameter int SW    = MAX_ORDER,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             shift_en,
  input  logic             use_pred,
  input  logic             in_bit,
  input  logic [SEL_W-1:0] sel,
  output logic             pred_bit,
  output logic             state_nz
);

  // st[0] holds the newest bit, st[k] the bit k+1 positions back
  logic [SW-1:0]         st;
  logic [NUM_ORDERS-1:0] pv;
  logic [NUM_ORDERS-1:0] nv;

  genvar g;
  generate
    for (g = 0; g < NUM_ORDERS; g++) begin : g_ord
      localparam int HI = tap_hi(g);
      localparam int LO = tap_lo(g);
      assign pv[g] = st[HI-1] ^ st[LO-1];
      assign nv[g] = |st[HI-1:0];
    end
  endgenerate

  always_comb begin
    pred_bit = pv[0];
    state_nz = nv[0];
    for (int i = 1; i < NUM_ORDERS; i++) begin
      if (sel == SEL_W'(i)) begin
        pred_bit = pv[i];
        state_nz = nv[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      st <= '0;
    end else if (shift_en) begin
      st <= {st[SW-2:0], (use_pred ? pred_bit : in_bit)};
    end
  end

endmodule

// File: rtl/prbs_lock_fsm.sv
module prbs_lock_fsm
  import prbs_det_pkg::*;
#(
  parameter int LOCK_RUN  = 64,
  parameter int WIN_LEN   = 256,
  parameter int ERR_LIMIT = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       in_valid,
  input  logic       mism,
  input  logic       state_nz,
  input  logic       at_target,
  output det_state_t state_o,
  output logic       lol_o
);

  localparam int MW = $clog2(LOCK_RUN);
  localparam int WW = $clog2(WIN_LEN);
  localparam int EW = $clog2(ERR_LIMIT + 1);

  det_state_t    st;
  logic [MW-1:0] run_q;
  logic [WW-1:0] win_q;
  logic [EW-1:0] werr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      run_q  <= '0;
      win_q  <= '0;
      werr_q <= '0;
      lol_o  <= 1'b0;
    end else if (start) begin
      st     <= ST_SYNC;
      run_q  <= '0;
      win_q  <= '0;
      werr_q <= '0;
      lol_o  <= 1'b0;
    end else begin
      case (st)
        ST_SYNC: begin
          if (in_valid) begin
            if (!mism && state_nz) begin
              if (run_q == MW'(LOCK_RUN - 1)) begin
                st     <= ST_LOCK;
                run_q  <= '0;
                win_q  <= '0;
                werr_q <= '0;
              end else begin
                run_q <= run_q + 1'b1;
              end
            end else begin
              run_q <= '0;
            end
          end
        end
        ST_LOCK: begin
          if (at_target) begin
            st <= ST_DONE;
          end else if (in_valid) begin
            if (mism && (werr_q == EW'(ERR_LIMIT))) begin
              st    <= ST_SYNC;
              lol_o <= 1'b1;
              run_q <= '0;
            end else if (win_q == WW'(WIN_LEN - 1)) begin
              win_q  <= '0;
              werr_q <= '0;
            end else begin
              win_q  <= win_q + 1'b1;
              werr_q <= werr_q + EW'(mism);
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign state_o = st;

endmodule

// File: rtl/prbs_sat_counter.sv
module prbs_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (inc && !(&count)) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/prbs_err_det.sv
module prbs_err_det
  import prbs_det_pkg::*;
#(
  parameter int CNT_W     = 48,
  parameter int ERR_W     = 32,
  parameter int LOCK_RUN  = 64,
  parameter int WIN_LEN   = 256,
  parameter int ERR_LIMIT = 16,
  parameter int SEL_W     = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [SEL_W-1:0] order_sel,
  input  logic [CNT_W-1:0] target_bits,
  input  logic             in_valid,
  input  logic             in_bit,
  output logic             locked,
  output logic             done,
  output logic             loss_of_lock,
  output logic [CNT_W-1:0] bit_count,
  output logic [ERR_W-1:0] err_count
);

  det_state_t       st;
  logic [SEL_W-1:0] order_q;
  logic             pred_bit;
  logic             state_nz;
  logic             mism;
  logic             at_target;
  logic             cnt_en;
  logic             shift_en;

  // order code is captured only when a test starts; unknown codes fall back to 0
  always_ff @(posedge clk) begin
    if (rst) begin
      order_q <= '0;
    end else if (start) begin
      order_q <= (int'(order_sel) < NUM_ORDERS) ? order_sel : '0;
    end
  end

  assign mism      = pred_bit ^ in_bit;
  assign at_target = (bit_count == target_bits);
  assign cnt_en    = (st == ST_LOCK) && in_valid && !at_target;
  assign shift_en  = ((st == ST_SYNC) && in_valid) || cnt_en;

  prbs_predictor #(
    .SW   (MAX_ORDER),
    .SEL_W(SEL_W)
  ) u_pred (
    .clk     (clk),
    .rst     (rst),
    .clr     (start),
    .shift_en(shift_en),
    .use_pred(st == ST_LOCK),
    .in_bit  (in_bit),
    .sel     (order_q),
    .pred_bit(pred_bit),
    .state_nz(state_nz)
  );

  prbs_lock_fsm #(
    .LOCK_RUN (LOCK_RUN),
    .WIN_LEN  (WIN_LEN),
    .ERR_LIMIT(ERR_LIMIT)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .in_valid (in_valid),
    .mism     (mism),
    .state_nz (state_nz),
    .at_target(at_target),
    .state_o  (st),
    .lol_o    (loss_of_lock)
  );

  prbs_sat_counter #(.W(CNT_W)) u_bits (
    .clk  (clk),
    .rst  (rst),
    .clr  (start),
    .inc  (cnt_en),
    .count(bit_count)
  );

  prbs_sat_counter #(.W(ERR_W)) u_errs (
    .clk  (clk),
    .rst  (rst),
    .clr  (start),
    .inc  (cnt_en && mism),
    .count(err_count)
  );

  assign locked = (st == ST_LOCK);
  assign done   = (st == ST_DONE);

endmodule

// File: rtl/prbs_err_det_chk.sv
module prbs_err_det_chk #(
  parameter int CNT_W = 48,
  parameter int ERR_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [CNT_W-1:0] target_bits,
  input logic             in_valid,
  input logic             locked,
  input logic             done,
  input logic             loss_of_lock,
  input logic [CNT_W-1:0] bit_count,
  input logic [ERR_W-1:0] err_count
);

  // R1: a start pulse leaves a clean, unlocked test behind it
  a_r1_start_clears: assert property (@(posedge clk) disable iff (rst)
    start |=> (bit_count == '0 && err_count == '0 && !loss_of_lock && !locked && !done));

  // R5: the bit counter only moves for a valid bit seen while locked
  a_r5_count_needs_lock: assert property (@(posedge clk) disable iff (rst)
    (!$past(start) && bit_count != $past(bit_count)) |-> $past(locked && in_valid));

  // R5: every error is also a counted bit
  a_r5_err_le_bits: assert property (@(posedge clk) disable iff (rst)
    64'(err_count) <= 64'(bit_count));

  // R7: nothing is counted once the target is reached
  a_r7_stop_at_target: assert property (@(posedge clk) disable iff (rst)
    (!$past(start) && $past(bit_count) == $past(target_bits)) |-> bit_count == $past(bit_count));

  // R7: done is held until the next start
  a_r7_done_held: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  // R8: the loss flag is sticky
  a_r8_lol_sticky: assert property (@(posedge clk) disable iff (rst)
    (loss_of_lock && !start) |=> loss_of_lock);

  // R9: a full error counter stays full
  a_r9_err_sat: assert property (@(posedge clk) disable iff (rst)
    ((&err_count) && !start) |=> (&err_count));

endmodule

bind prbs_err_det prbs_err_det_chk #(
  .CNT_W(CNT_W),
  .ERR_W(ERR_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .target_bits (target_bits),
  .in_valid    (in_valid),
  .locked      (locked),
  .done        (done),
  .loss_of_lock(loss_of_lock),
  .bit_count   (bit_count),
  .err_count   (err_count)
);

// File: tb/prbs_err_det_tb.sv
`timescale 1ns/1ps
module prbs_err_det_tb;

  localparam int CW = 48;
  localparam int EW = 8;
  localparam longint ERR_MAX = (64'd1 << EW) - 1;
  localparam longint BIT_MAX = (64'd1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [2:0]    order_sel = '0;
  logic [CW-1:0] target_bits = '0;
  logic          in_valid = 1'b0;
  logic          in_bit = 1'b0;
  logic          locked, done, loss_of_lock;
  logic [CW-1:0] bit_count;
  logic [EW-1:0] err_count;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;

  always #5 clk = ~clk;

  prbs_err_det #(.CNT_W(CW), .ERR_W(EW)) u_dut (
    .clk(clk), .rst(rst), .start(start), .order_sel(order_sel),
    .target_bits(target_bits), .in_valid(in_valid), .in_bit(in_bit),
    .locked(locked), .done(done), .loss_of_lock(loss_of_lock),
    .bit_count(bit_count), .err_count(err_count)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int hi_of(input int c);
    case (c) 1: return 9; 2: return 15; 3: return 23; 4: return 31; default: return 7; endcase
  endfunction
  function automatic int lo_of(input int c);
    case (c) 1: return 5; 2: return 14; 3: return 18; 4: return 28; default: return 6; endcase
  endfunction

  // ---------------- behavioural reference model ----------------
  localparam int M_IDLE = 0, M_SYNC = 1, M_LOCK = 2, M_DONE = 3;
  int     mstate = M_IDLE;
  bit     mh[$];
  longint mbc = 0, mec = 0;
  int     mrun = 0, mwin = 0, mwerr = 0, ma = 7, mb = 6;
  bit     mlol = 1'b0;

  always @(posedge clk) begin
    bit p, nz, e;
    if (rst) begin
      mstate = M_IDLE; mbc = 0; mec = 0; mrun = 0; mwin = 0; mwerr = 0; mlol = 0;
      mh.delete();
      repeat (31) mh.push_back(1'b0);
    end else if (start) begin
      ma = hi_of(int'(order_sel)); mb = lo_of(int'(order_sel));
      mh.delete();
      repeat (31) mh.push_back(1'b0);
      mstate = M_SYNC; mbc = 0; mec = 0; mrun = 0; mwin = 0; mwerr = 0; mlol = 0;
    end else if (mstate == M_LOCK && mbc == longint'(target_bits)) begin
      mstate = M_DONE;
    end else if (in_valid && (mstate == M_SYNC || mstate == M_LOCK)) begin
      p = mh[ma-1] ^ mh[mb-1];
      nz = 1'b0;
      for (int i = 0; i < ma; i++) nz |= mh[i];
      if (mstate == M_SYNC) begin
        if (p == in_bit && nz) begin
          mrun++;
          if (mrun == 64) begin mstate = M_LOCK; mrun = 0; mwin = 0; mwerr = 0; end
        end else begin
          mrun = 0;
        end
        mh.push_front(in_bit);
      end else begin
        e = (p != in_bit);
        if (mbc < BIT_MAX) mbc++;
        if (e && mec < ERR_MAX) mec++;
        if (e && mwerr == 16) begin
          mstate = M_SYNC; mlol = 1; mrun = 0;
        end else if (mwin == 255) begin
          mwin = 0; mwerr = 0;
        end else begin
          mwin++; mwerr += int'(e);
        end
        mh.push_front(p);
      end
      void'(mh.pop_back());
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R3 R8 cycle locked", longint'(locked), longint'(mstate == M_LOCK));
      chk("R7 cycle done", longint'(done), longint'(mstate == M_DONE));
      chk("R8 cycle loss_of_lock", longint'(loss_of_lock), longint'(mlol));
      chk("R5 R9 cycle bit_count", longint'(bit_count), mbc);
      chk("R5 R6 R9 cycle err_count", longint'(err_count), mec);
    end
  end

  // ---------------- stimulus generator ----------------
  bit gq[$];
  int ga = 7, gb = 6;

  task automatic gen_init(input int code);
    ga = hi_of(code); gb = lo_of(code);
    gq.delete();
    repeat (31) gq.push_back(1'b1);
  endtask

  task automatic gen_next(output bit b);
    b = gq[ga-1] ^ gq[gb-1];
    gq.push_front(b);
    void'(gq.pop_back());
  endtask

  task automatic do_start(input int code, input longint tgt);
    order_sel = 3'(code);
    target_bits = CW'(tgt);
    in_valid = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    gen_init(code);
  endtask

  // sends n pattern bits; flips every period-th one while locked
  task automatic feed(input int n, input int period);
    for (int k = 1; k <= n; k++) begin
      bit b;
      gen_next(b);
      in_valid = 1'b1;
      in_bit = b ^ (period > 0 && locked && (k % period == 0));
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic feed_until_lock(input int maxn, output int n);
    n = 0;
    while (!locked && n < maxn) begin
      bit b;
      gen_next(b);
      in_valid = 1'b1;
      in_bit = b;
      @(negedge clk);
      n++;
    end
    in_valid = 1'b0;
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    longint snap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cmp_on = 1'b1;
    chk("R1 reset locked", longint'(locked), 0);
    chk("R1 reset done", longint'(done), 0);
    chk("R1 reset bit_count", longint'(bit_count), 0);
    chk("R1 reset err_count", longint'(err_count), 0);

    // order 7: clean run to target, then done held
    do_start(0, 1000);
    feed_until_lock(200, n);
    chk("R3 lock latency order 7", longint'(n >= 64 && n <= 71), 1);
    feed(1100, 0);
    chk("R7 done at target", longint'(done), 1);
    chk("R7 bit_count equals target", longint'(bit_count), 1000);
    chk("R5 clean err_count", longint'(err_count), 0);
    feed(50, 0);
    chk("R7 count frozen after done", longint'(bit_count), 1000);
    chk("R7 done held", longint'(done), 1);

    // order 31: isolated flips give one error each
    do_start(4, 3000);
    feed_until_lock(200, n);
    chk("R3 lock latency order 31", longint'(n >= 64 && n <= 95), 1);
    feed(2600, 500);
    chk("R6 single flips counted once", longint'(err_count), 5);
    feed(500, 0);
    chk("R7 done order 31", longint'(bit_count), 3000);

    // orders 9, 15, 23
    for (int c = 1; c <= 3; c++) begin
      do_start(c, 400);
      feed_until_lock(150, n);
      chk("R2 R3 lock latency", longint'(n >= 64 && n <= hi_of(c) + 64), 1);
      feed(200, 100);
      chk("R2 R6 two errors", longint'(err_count), 2);
      feed(250, 0);
      chk("R2 R7 done", longint'(done), 1);
    end

    // out-of-range code behaves as order 7
    do_start(6, 300);
    feed_until_lock(150, n);
    chk("R2 code 6 locks on order 7", longint'(locked), 1);
    feed(400, 0);
    chk("R2 code 6 done", longint'(done), 1);
    chk("R2 code 6 no errors", longint'(err_count), 0);

    // all-zero stream never locks
    do_start(0, 100);
    for (int k = 0; k < 300; k++) begin
      in_valid = 1'b1; in_bit = 1'b0;
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk("R4 zero stream not locked", longint'(locked), 0);
    chk("R4 zero stream no bits", longint'(bit_count), 0);

    // strobe gaps with junk data, and order_sel changed mid-run
    do_start(2, 500);
    feed_until_lock(150, n);
    order_sel = 3'd4;
    for (int k = 0; k < 900; k++) begin
      if (k % 3 == 2) begin
        in_valid = 1'b0;
        in_bit = k[0];
      end else begin
        bit b;
        gen_next(b);
        in_valid = 1'b1;
        in_bit = b;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk("R5 gaps bit_count", longint'(bit_count), 500);
    chk("R5 R2 gaps no errors", longint'(err_count), 0);
    chk("R7 gaps done", longint'(done), 1);

    // burst loss of lock, recovery, restart
    do_start(2, 100000);
    feed_until_lock(150, n);
    feed(50, 0);
    feed(17, 1);
    chk("R8 lock dropped", longint'(locked), 0);
    chk("R8 loss flag set", longint'(loss_of_lock), 1);
    chk("R8 burst errors", longint'(err_count), 17);
    snap = longint'(bit_count);
    feed(10, 0);
    chk("R8 sync bits not counted", longint'(bit_count), snap);
    feed(200, 0);
    chk("R8 relocked", longint'(locked), 1);
    chk("R8 flag sticky", longint'(loss_of_lock), 1);
    do_start(0, 10);
    chk("R1 start clears bit_count", longint'(bit_count), 0);
    chk("R1 start clears err_count", longint'(err_count), 0);
    chk("R1 start clears loss flag", longint'(loss_of_lock), 0);

    // error counter saturation
    do_start(0, 6000);
    feed_until_lock(150, n);
    feed(5900, 20);
    chk("R9 err_count saturated", longint'(err_count), ERR_MAX);
    chk("R9 still locked", longint'(locked), 1);

    cmp_on = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule